// File: doc/BRIEF.md
# Set-Associative Cache Controller

This block is a parameterised set-associative cache placed between a processor-side request port and a lower-level memory port. A request carries a 32-bit byte address, a read/write flag, a data word and byte strobes. The address is cut into a line offset, a set index and a tag. All ways of the indexed set are compared at once, and hits are served straight from the line store. A miss runs a small state machine that may write a dirty victim back, fetches the whole line as a burst of word beats, and then serves the access.

Two compile-time parameters choose the write policy. `WRITE_BACK` selects between a write-back cache, where write hits stay local and mark the line dirty, and a write-through cache, where every write hit is also sent below and lines stay clean. `WRITE_ALLOC` selects whether a write miss allocates a line, filling it first and merging the store afterwards, or simply forwards the store to lower memory. Victim choice sits in its own selector: a free way is used when one exists, and otherwise a per-set rotating pointer picks the way.

The lower port moves one word per handshake. A beat completes in a cycle where both `mem_valid` and `mem_ready` are high. On a read beat, `mem_rdata` must be valid in that same cycle.

Top module: `cache_ctrl`

## Requirements
- R1: Address fields follow the geometry: byte offset is the low log2(LINE_BYTES) bits (4 by default), set index is the next log2(LINES/WAYS) bits (bits 5:4 by default), and the tag is the rest. Lines in different sets never displace each other.
- R2: After reset no line is valid and no line is dirty, `req_ready` is high, and the first read of any address misses.
- R3: A read whose set holds a valid way with a matching tag returns that word and makes no lower-memory transfer. At most one way of a set matches.
- R4: A line fill issues exactly WORDS read beats at ascending word addresses from the line base. The requested word is returned once the fill is done. While a beat waits for `mem_ready`, its address is held.
- R5: On a miss, an invalid way of the set is filled first. When every way is valid, a per-set pointer picks the victim. The pointer starts at way 0 and advances by one, wrapping, after each fill of that set. A clean victim is replaced with no write beats.
- R6: In write-back mode a dirty victim is written out as WORDS full-strobe write beats at its own line addresses, ascending, before the fill starts. Its data stays readable afterwards.
- R7: In write-back mode a write hit makes no lower-memory transfer and marks the line dirty.
- R8: In write-through mode each write hit produces exactly one lower-memory write, with the request's word address, data and strobes. No line is ever dirty, so evictions never write back.
- R9: In write-allocate mode a write miss fetches the whole line first and then merges the store. A following read of that address hits and returns the stored value.
- R10: In no-write-allocate mode a write miss makes one lower-memory write and no read beats. No line is allocated, so a following read of that address misses.
- R11: Once a request is accepted, `req_ready` stays low until the response. `resp_valid` is a single-cycle pulse, and each request gets exactly one.
- R12: A write changes only the bytes whose strobe bit is set (strobe bit b covers data bits 8b+7:8b). All other bytes of the word keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_wstrb | input | DATA_W/8 | Store byte strobes |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load data, valid with resp_valid on loads |
| mem_valid | output | 1 | Lower-memory beat request |
| mem_ready | input | 1 | Lower memory completes the beat this cycle |
| mem_write | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | DATA_W | Write beat data |
| mem_wstrb | output | DATA_W/8 | Write beat byte strobes |
| mem_rdata | input | DATA_W | Read beat data, same cycle as mem_ready |

## Verification
The sequence is run under all four policy combinations, and the lower-memory read and write beats are counted around every access. Repeated reads of a resident line separate hits from misses. A third tag in one set separates clean replacement from dirty write-back, and it also shows which way the rotating pointer picked. Stores with partial strobes, followed by reads, separate the merge from a whole-word overwrite. A store to an absent line followed by a read separates allocate from no-allocate. Reads in other sets show that the index bits keep sets apart. Every load is compared with a flat reference array that holds the architectural memory contents.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_LOOKUP,
    CS_WBACK,
    CS_FILL,
    CS_FWD,
    CS_RESP
  } cc_state_e;
endpackage

// File: rtl/cache_tag_cmp.sv
module cache_tag_cmp #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 26,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]            set_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign hit_vec[g] = set_valid[g] && (set_tags[g] == req_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
    end
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  set_valid,
  input  logic [IDX_W-1:0] idx,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic             found;

  always_comb begin
    victim = ptr_q[idx];
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !set_valid[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (advance) begin
      ptr_q[idx] <= (ptr_q[idx] == WAY_W'(WAYS-1)) ? '0 : ptr_q[idx] + WAY_W'(1);
    end
  end

  // R5: a free way is always taken before an occupied one
  p_prefer_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~set_valid)) |-> !set_valid[victim]);

  // R5: rotating pointer never names a way that does not exist
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ptr_q[idx]) < WAYS));
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINES       = 8,
  parameter int WAYS        = 2,
  parameter int LINE_BYTES  = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_wstrb,
  output logic                resp_valid,
  output logic [DATA_W-1:0]   resp_rdata,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_write,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_wstrb,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int BYTES_W = DATA_W / 8;
  localparam int SETS    = LINES / WAYS;
  localparam int WORDS   = LINE_BYTES / BYTES_W;
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int BSEL_W  = $clog2(BYTES_W);
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  cc_state_e state_q, state_d;
  logic              rq_write_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic [BYTES_W-1:0] rq_wstrb_q;
  logic [WSEL_W-1:0] beat_q;
  logic [WAY_W-1:0]  victim_q;
  logic [DATA_W-1:0] rdata_q;

  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS][WORDS];

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_word;
  assign a_tag  = rq_addr_q[ADDR_W-1 -: TAG_W];
  assign a_idx  = rq_addr_q[OFF_W +: IDX_W];
  assign a_word = rq_addr_q[BSEL_W +: WSEL_W];

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0] hit_vec;
  logic            hit;
  logic [WAY_W-1:0] hit_way, victim_w;

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[a_idx][w];
  end

  cache_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_cmp (
    .set_valid (valid_q[a_idx]),
    .set_tags  (set_tags),
    .req_tag   (a_tag),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  logic mem_go, last_beat, fill_done, wr_hit, rd_hit, accept, victim_dirty;
  assign mem_go       = mem_valid && mem_ready;
  assign last_beat    = (beat_q == LAST_BEAT);
  assign fill_done    = (state_q == CS_FILL) && mem_go && last_beat;
  assign wr_hit       = (state_q == CS_LOOKUP) && hit && rq_write_q;
  assign rd_hit       = (state_q == CS_LOOKUP) && hit && !rq_write_q;
  assign accept       = (state_q == CS_IDLE) && req_valid;
  assign victim_dirty = valid_q[a_idx][victim_w] && dirty_q[a_idx][victim_w];

  cache_victim_sel #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_vsel (
    .clk       (clk),
    .rst_n     (rst_ni),
    .set_valid (valid_q[a_idx]),
    .idx       (a_idx),
    .advance   (fill_done),
    .victim    (victim_w)
  );

  logic [DATA_W-1:0] hit_word, merged;
  always_comb begin
    hit_word = data_q[a_idx][hit_way][a_word];
    merged   = hit_word;
    for (int b = 0; b < BYTES_W; b++) begin
      if (rq_wstrb_q[b]) merged[8*b +: 8] = rq_wdata_q[8*b +: 8];
    end
  end

  // next state and lower-port drive
  always_comb begin
    state_d   = state_q;
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    unique case (state_q)
      CS_IDLE: if (req_valid) state_d = CS_LOOKUP;
      CS_LOOKUP: begin
        if (hit)                            state_d = (rq_write_q && !WRITE_BACK) ? CS_FWD : CS_RESP;
        else if (!rq_write_q || WRITE_ALLOC) state_d = victim_dirty ? CS_WBACK : CS_FILL;
        else                                state_d = CS_FWD;
      end
      CS_WBACK: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {tag_q[a_idx][victim_q], a_idx, beat_q, {BSEL_W{1'b0}}};
        mem_wdata = data_q[a_idx][victim_q][beat_q];
        mem_wstrb = '1;
        if (mem_ready && last_beat) state_d = CS_FILL;
      end
      CS_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {a_tag, a_idx, beat_q, {BSEL_W{1'b0}}};
        if (mem_ready && last_beat) state_d = CS_LOOKUP;
      end
      CS_FWD: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = rq_addr_q;
        mem_wdata = rq_wdata_q;
        mem_wstrb = rq_wstrb_q;
        if (mem_ready) state_d = CS_RESP;
      end
      CS_RESP: state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CS_IDLE;
      beat_q   <= '0;
      victim_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == CS_LOOKUP) victim_q <= victim_w;
      if (mem_go && (state_q == CS_WBACK || state_q == CS_FILL))
        beat_q <= last_beat ? '0 : beat_q + WSEL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rq_write_q <= req_write;
      rq_addr_q  <= req_addr;
      rq_wdata_q <= req_wdata;
      rq_wstrb_q <= req_wstrb;
    end
    if (rd_hit) rdata_q <= hit_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_done) begin
        valid_q[a_idx][victim_q] <= 1'b1;
        dirty_q[a_idx][victim_q] <= 1'b0;
      end
      if (wr_hit && WRITE_BACK) dirty_q[a_idx][hit_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[a_idx][victim_q] <= a_tag;
    if ((state_q == CS_FILL) && mem_go) data_q[a_idx][victim_q][beat_q] <= mem_rdata;
    if (wr_hit) data_q[a_idx][hit_way][a_word] <= merged;
  end

  assign req_ready  = (state_q == CS_IDLE);
  assign resp_valid = (state_q == CS_RESP);
  assign resp_rdata = rdata_q;

  // R11: an accepted request closes the port on the next cycle
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready) |=> !req_ready);

  // R11: completion is a single-cycle pulse
  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    resp_valid |=> !resp_valid);

  // R4: a stalled beat keeps its request and address
  p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R3: the tag store never holds two valid copies of one line in a set
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == CS_LOOKUP) |-> $onehot0(hit_vec));

  if (!WRITE_BACK) begin : g_wt_check
    logic dirty_any;
    always_comb begin
      dirty_any = 1'b0;
      for (int s = 0; s < SETS; s++) dirty_any = dirty_any | (|dirty_q[s]);
    end
    // R8: write-through lines stay clean
    p_never_dirty_r8: assert property (@(posedge clk) disable iff (!rst_ni) !dirty_any);
  end
endmodule

// File: tb/sim_cache_ctrl.sv
module sim_cache_harness #(
  parameter bit WB = 1'b1,
  parameter bit WA = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_bad
);
  localparam int WORDS = 4;

  logic        req_valid, req_ready, req_write, resp_valid;
  logic [31:0] req_addr, req_wdata, resp_rdata;
  logic [3:0]  req_wstrb;
  logic        mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;

  cache_ctrl #(.WRITE_BACK(WB), .WRITE_ALLOC(WA)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_rdata(mem_rdata)
  );

  logic [31:0] lmem [256];
  logic [31:0] refm [256];
  logic [31:0] log_a [64];
  int rd_beats, wr_beats, log_n, rdy_cnt;

  function automatic logic [31:0] initv(int i);
    return 32'h5A5A0000 + i * 32'h00000317;
  endfunction

  function automatic logic [31:0] ad(int t, int s, int w);
    return 32'(t * 64 + s * 16 + w * 4);
  endfunction

  assign mem_rdata = lmem[mem_addr[9:2]];
  assign mem_ready = (rdy_cnt != 0);

  always @(negedge clk) begin
    if (!rst_n) rdy_cnt <= 0;
    else        rdy_cnt <= (rdy_cnt + 1) % 3;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) lmem[i] <= initv(i);
      rd_beats <= 0;
      wr_beats <= 0;
      log_n    <= 0;
    end else if (mem_valid && mem_ready) begin
      log_a[log_n % 64] <= mem_addr;
      log_n <= log_n + 1;
      if (mem_write) begin
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) lmem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_beats <= wr_beats + 1;
      end else begin
        rd_beats <= rd_beats + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [wb=%0d wa=%0d] %s: got %h expected %h", req, WB, WA, what, got, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd,
                        output int drd, output int dwr, output int log0);
    int r0, w0, n;
    bit busy_bad;
    @(negedge clk);
    r0 = rd_beats; w0 = wr_beats; log0 = log_n;
    req_write = wr; req_addr = a; req_wdata = d; req_wstrb = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 1'b0;
    n = 0;
    while (!resp_valid && n < 500) begin
      if (req_ready) busy_bad = 1'b1;
      n++;
      @(negedge clk);
    end
    if (req_ready || !resp_valid) busy_bad = 1'b1;
    rd  = resp_rdata;
    drd = rd_beats - r0;
    dwr = wr_beats - w0;
    chk(!busy_bad, "R11", "ready low until one response", {31'b0, busy_bad}, 32'd0);
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (s[b]) refm[a[9:2]][8*b +: 8] = d[8*b +: 8];
    end
    @(negedge clk);
    chk(req_ready && !resp_valid, "R11", "pulse ends and port reopens",
        {30'b0, req_ready, resp_valid}, 32'd2);
  endtask

  task automatic op(input bit wr, input logic [31:0] a, input logic [31:0] d,
                    input logic [3:0] s, input int exp_rd, input int exp_wr,
                    input string req, output int log0);
    logic [31:0] rd;
    int drd, dwr;
    access(wr, a, d, s, rd, drd, dwr, log0);
    chk(drd == exp_rd, req, "read beats", drd, exp_rd);
    chk(dwr == exp_wr, req, "write beats", dwr, exp_wr);
    if (!wr) chk(rd == refm[a[9:2]], req, "load data", rd, refm[a[9:2]]);
  endtask

  task automatic t_reset();
    int l0;
    chk(req_ready == 1'b1, "R2", "ready after reset", {31'b0, req_ready}, 32'd1);
    op(1'b0, ad(0,0,1), 0, 0, WORDS, 0, "R2", l0);
    for (int k = 0; k < WORDS; k++)
      chk(log_a[(l0 + k) % 64] == ad(0,0,k), "R4", "fill beat address",
          log_a[(l0 + k) % 64], ad(0,0,k));
  endtask

  task automatic t_read_hit();
    int l0;
    op(1'b0, ad(0,0,2), 0, 0, 0, 0, "R3", l0);
    op(1'b0, ad(0,0,3), 0, 0, 0, 0, "R3", l0);
  endtask

  task automatic t_write_hit();
    int l0;
    op(1'b1, ad(0,0,1), 32'hDEADBEEF, 4'b0101, 0, WB ? 0 : 1, WB ? "R7" : "R8", l0);
    if (!WB) chk(log_a[l0 % 64] == ad(0,0,1), "R8", "forwarded address", log_a[l0 % 64], ad(0,0,1));
    op(1'b0, ad(0,0,1), 0, 0, 0, 0, "R12", l0);
  endtask

  task automatic t_second_way();
    int l0;
    op(1'b0, ad(1,0,0), 0, 0, WORDS, 0, "R5", l0);
    op(1'b0, ad(0,0,0), 0, 0, 0, 0, "R5", l0);
  endtask

  task automatic t_evict();
    int l0;
    op(1'b0, ad(2,0,2), 0, 0, WORDS, WB ? WORDS : 0, WB ? "R6" : "R8", l0);
    if (WB) begin
      for (int k = 0; k < WORDS; k++) begin
        chk(log_a[(l0 + k) % 64] == ad(0,0,k), "R6", "write-back beat address",
            log_a[(l0 + k) % 64], ad(0,0,k));
        chk(log_a[(l0 + WORDS + k) % 64] == ad(2,0,k), "R6", "fill after write-back",
            log_a[(l0 + WORDS + k) % 64], ad(2,0,k));
      end
    end
    op(1'b0, ad(0,0,1), 0, 0, WORDS, 0, "R6", l0);
    op(1'b0, ad(2,0,0), 0, 0, 0, 0, "R5", l0);
  endtask

  task automatic t_index();
    int l0;
    op(1'b0, ad(0,2,0), 0, 0, WORDS, 0, "R1", l0);
    op(1'b0, ad(1,3,0), 0, 0, WORDS, 0, "R1", l0);
    op(1'b0, ad(2,0,3), 0, 0, 0, 0, "R1", l0);
    op(1'b0, ad(0,0,2), 0, 0, 0, 0, "R1", l0);
  endtask

  task automatic t_write_miss();
    int l0;
    if (WA) begin
      op(1'b1, ad(3,1,0), 32'h13579BDF, 4'hF, WORDS, WB ? 0 : 1, "R9", l0);
      if (!WB) chk(log_a[(l0 + WORDS) % 64] == ad(3,1,0), "R9", "store after fill",
                   log_a[(l0 + WORDS) % 64], ad(3,1,0));
      op(1'b0, ad(3,1,0), 0, 0, 0, 0, "R9", l0);
    end else begin
      op(1'b1, ad(3,1,0), 32'h13579BDF, 4'hF, 0, 1, "R10", l0);
      op(1'b0, ad(3,1,0), 0, 0, WORDS, 0, "R10", l0);
    end
  endtask

  task automatic t_strobe();
    int l0;
    op(1'b1, ad(0,2,1), 32'hA1B2C3D4, 4'b1000, 0, WB ? 0 : 1, "R12", l0);
    op(1'b0, ad(0,2,1), 0, 0, 0, 0, "R12", l0);
  endtask

  initial begin
    done = 1'b0; n_chk = 0; n_bad = 0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_wstrb = '0;
    for (int i = 0; i < 256; i++) refm[i] = initv(i);
    wait (rst_n === 1'b1);
    repeat (4) @(negedge clk);
    t_reset();
    t_read_hit();
    t_write_hit();
    t_second_way();
    t_evict();
    t_index();
    t_write_miss();
    t_strobe();
    done = 1'b1;
  end
endmodule

module sim_cache_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk, rst_n;
  logic d0, d1, d2, d3;
  int c0, c1, c2, c3, b0, b1, b2, b3;

  sim_cache_harness #(.WB(1'b1), .WA(1'b1)) h_wb_wa  (.clk(clk), .rst_n(rst_n), .done(d0), .n_chk(c0), .n_bad(b0));
  sim_cache_harness #(.WB(1'b1), .WA(1'b0)) h_wb_nwa (.clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_bad(b1));
  sim_cache_harness #(.WB(1'b0), .WA(1'b1)) h_wt_wa  (.clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_bad(b2));
  sim_cache_harness #(.WB(1'b0), .WA(1'b0)) h_wt_nwa (.clk(clk), .rst_n(rst_n), .done(d3), .n_chk(c3), .n_bad(b3));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    int cyc, tot, bad;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1 && d3 === 1'b1) && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    tot = c0 + c1 + c2 + c3;
    bad = b0 + b1 + b2 + b3;
    if (cyc >= WATCHDOG) begin
      tot++;
      bad++;
      $display("FAIL R11 watchdog: got %0d cycles without completion expected fewer than %0d", cyc, WATCHDOG);
    end
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  end
endmodule